// File: doc/BRIEF.md
# Timer Count Strobe Qualifier

This block sits in front of a low-power timer core and produces the strobe that tells the core when to count. Four clock-enable strobes arrive on a single system clock, and a select field picks one of them as the source. In time mode the block is a power-of-two prescaler. It issues one single-cycle tick each time the selected source has strobed a programmed number of times.

In pulse mode the same counter becomes a glitch filter on an external input. A new input level reaches the output only after the input has differed from the last accepted level for a programmed number of consecutive source strobes. If the input returns to the accepted level early, the count starts again. A bypass control, or a shift value of zero in pulse mode, removes the counting: ticks follow every source strobe, and the filtered level follows the input one cycle later.

The shift value N is 4 bits wide. It sets a divide ratio of 2^(N+1) in time mode and a filter depth of 2^N strobes in pulse mode. The divider and filter counts clear while the timer is disabled, and they also clear in any cycle in which the source select or N changes.

Top module: `strobe_qualifier`

## Requirements
- R1: Only the strobe at index `src_sel` of `src_stb` advances the divider or the filter; strobes on the other three sources have no effect on `tick_o` or `level_o`.
- R2: In time mode (`pulse_mode`=0) with `bypass`=0, `tick_o` is high for exactly one cycle, one cycle after every 2^(N+1)-th selected strobe counted from the last clear, and is low otherwise.
- R3: In time mode with `bypass`=1, `tick_o` is high one cycle after every selected strobe.
- R4: In pulse mode with `bypass`=0 and N from 1 to 15, `level_o` takes the value of `sig_in` one cycle after the 2^N-th selected strobe during which `sig_in` has differed from `level_o` without a break.
- R5: In pulse mode, if `sig_in` equals `level_o` for any cycle before the filter count completes, the count restarts from zero and `level_o` does not change.
- R6: In pulse mode with `bypass`=1 or N=0, `level_o` equals the value `sig_in` had one cycle earlier, whatever the strobes do.
- R7: `tick_o` is never high in the cycle after one with `pulse_mode`=1, and `level_o` does not change while in time mode.
- R8: While `tmr_en`=0 the counts clear, `tick_o` stays low and `level_o` holds. Counting restarts from zero after re-enable.
- R9: A change of `src_sel` or `shift_n` clears the divider and filter counts in the cycle it is seen, so a full new period is needed before the next tick or level change.
- R10: During and right after reset, `tick_o` and `level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer enable; 0 clears the counts |
| pulse_mode | input | 1 | 0 = time mode (prescaler), 1 = pulse mode (filter) |
| src_sel | input | 2 | Index of the source strobe used |
| bypass | input | 1 | 1 = skip the prescaler and filter |
| shift_n | input | 4 | N: divide by 2^(N+1), or filter for 2^N strobes |
| src_stb | input | 4 | Clock-enable strobes of the four sources |
| sig_in | input | 1 | Pulse input, already synchronous to clk |
| tick_o | output | 1 | Single-cycle count strobe in time mode |
| level_o | output | 1 | Filtered input level in pulse mode |

## Verification
If the divider count is wrong, the next tick comes too early or too late. That shows at `tick_o` within one division period, at most 2^(N+1) selected strobes. A filter count that fails to clear on a returned input, or that advances on a foreign strobe, moves `level_o` sooner than 2^N strobes after the input changes. A lost clear after a disable or a configuration change shows as an early first tick or level change after that event. The sweeps therefore count strobes from every clear and compare each output sample with an expected value computed from the strobe index.

// File: rtl/qual_pkg.sv
package qual_pkg;
  localparam int unsigned QUAL_NSRC = 4;
  localparam int unsigned QUAL_N_W  = 4;

  // Time-mode divide ratio for shift value n: 2^(n+1)
  function automatic int unsigned div_ratio(input int unsigned n);
    return 32'd2 << n;
  endfunction

  // Pulse-mode filter depth for shift value n: 2^n strobes
  function automatic int unsigned filt_depth(input int unsigned n);
    return 32'd1 << n;
  endfunction
endpackage

// File: rtl/qual_div.sv
module qual_div
  import qual_pkg::*;
#(
  parameter int unsigned N_W = QUAL_N_W,
  localparam int unsigned C_W = 2 ** N_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           stb,
  input  logic           bypass,
  input  logic [N_W-1:0] shift,
  output logic           wrap
);
  logic [C_W-1:0] cnt;
  logic           last;

  assign last = (32'(cnt) + 32'd1) == div_ratio(32'(shift));
  assign wrap = !clr && stb && (bypass || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr || bypass)     cnt <= '0;
    else if (stb && last)       cnt <= '0;
    else if (stb)               cnt <= cnt + 1'b1;
  end

  AST_DIV_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < div_ratio(32'(shift))) || $past(clr) || !$stable(shift)); // R2
  AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9
endmodule

// File: rtl/qual_filt.sv
module qual_filt
  import qual_pkg::*;
#(
  parameter int unsigned N_W = QUAL_N_W,
  localparam int unsigned C_W = 2 ** N_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           pass,
  input  logic           clr,
  input  logic           stb,
  input  logic           din,
  input  logic [N_W-1:0] shift,
  output logic           lvl
);
  logic [C_W-1:0] fcnt;
  logic           done;

  assign done = (32'(fcnt) + 32'd1) == filt_depth(32'(shift));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      lvl  <= 1'b0;
    end else if (hold) begin
      fcnt <= '0;
    end else if (pass) begin
      fcnt <= '0;
      lvl  <= din;
    end else if (clr || (din == lvl)) begin
      fcnt <= '0;
    end else if (stb && done) begin
      fcnt <= '0;
      lvl  <= din;
    end else if (stb) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  AST_LVL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> ($past(pass) || $past(stb))); // R4
  AST_HOLD_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(lvl)); // R8
  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (din == lvl)) |=> (fcnt == '0)); // R5
endmodule

// File: rtl/strobe_qualifier.sv
module strobe_qualifier
  import qual_pkg::*;
#(
  parameter int unsigned NSRC = QUAL_NSRC,
  parameter int unsigned N_W  = QUAL_N_W,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             pulse_mode,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             bypass,
  input  logic [N_W-1:0]   shift_n,
  input  logic [NSRC-1:0]  src_stb,
  input  logic             sig_in,
  output logic             tick_o,
  output logic             level_o
);
  logic             sel_stb;
  logic             cfg_chg;
  logic             div_wrap;
  logic [SEL_W-1:0] sel_q;
  logic [N_W-1:0]   shift_q;

  assign sel_stb = src_stb[src_sel];
  assign cfg_chg = (sel_q != src_sel) || (shift_q != shift_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      shift_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      sel_q   <= src_sel;
      shift_q <= shift_n;
      tick_o  <= tmr_en && !pulse_mode && div_wrap;
    end
  end

  qual_div #(.N_W(N_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!tmr_en || pulse_mode || cfg_chg),
    .stb    (sel_stb),
    .bypass (bypass),
    .shift  (shift_n),
    .wrap   (div_wrap)
  );

  qual_filt #(.N_W(N_W)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (!tmr_en || !pulse_mode),
    .pass  (bypass || (shift_n == '0)),
    .clr   (cfg_chg),
    .stb   (sel_stb),
    .din   (sig_in),
    .shift (shift_n),
    .lvl   (level_o)
  );

  AST_NO_TICK_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_mode |=> !tick_o); // R7
  AST_TICK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(sel_stb)); // R1
  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !tick_o); // R8
  AST_TIME_LVL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode |=> $stable(level_o)); // R7
endmodule

// File: tb/sim_strobe_qualifier.sv
module sim_strobe_qualifier;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_en = 1'b0;
  logic       pulse_mode = 1'b0;
  logic [1:0] src_sel = '0;
  logic       bypass = 1'b0;
  logic [3:0] shift_n = '0;
  logic [3:0] src_stb = '0;
  logic       sig_in = 1'b0;
  logic       tick_o;
  logic       level_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  exp_lvl = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .pulse_mode(pulse_mode),
    .src_sel(src_sel), .bypass(bypass), .shift_n(shift_n),
    .src_stb(src_stb), .sig_in(sig_in), .tick_o(tick_o), .level_o(level_o)
  );

  task automatic check(input bit got, input bit exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic setup(input bit pm, input int sel, input bit byp, input int n);
    tmr_en = 1'b0; pulse_mode = pm; src_sel = 2'(sel); bypass = byp; shift_n = 4'(n);
    repeat (2) @(negedge clk);
    tmr_en = 1'b1;
    @(negedge clk);
  endtask

  // Strobe the selected source for one cycle; outputs are sampled at the next negedge.
  task automatic pulse(input int sel);
    src_stb = 4'(1 << sel);
    @(negedge clk);
    src_stb = '0;
  endtask

  // Strobe every other source for one cycle.
  task automatic noise(input int sel);
    src_stb = 4'hF & ~4'(1 << sel);
    @(negedge clk);
    src_stb = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick_o, 1'b0, "R10", "tick in reset");
    check(level_o, 1'b0, "R10", "level in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(tick_o, 1'b0, "R10", "tick after reset");
    check(level_o, 1'b0, "R10", "level after reset");

    // Time mode sweep: R2 divide, R3 bypass, R1 foreign strobes
    for (int n = 0; n <= 4; n++)
      for (int sel = 0; sel < 4; sel++)
        for (int byp = 0; byp < 2; byp++) begin
          int per;
          setup(1'b0, sel, byp[0], n);
          per = byp ? 1 : (2 << n);
          for (int i = 1; i <= 2 * per + 1; i++) begin
            pulse(sel);
            check(tick_o, (i % per) == 0, byp ? "R3" : "R2", "tick on strobe");
            noise(sel);
            check(tick_o, 1'b0, "R1", "tick on foreign strobe");
          end
        end

    // Time mode: input changes do not move the level (R7)
    setup(1'b0, 0, 1'b0, 0);
    sig_in = !exp_lvl;
    for (int i = 0; i < 4; i++) begin
      pulse(0);
      check(level_o, exp_lvl, "R7", "level in time mode");
    end

    // Pulse mode filter sweep: R4, R5, R1, R7
    for (int n = 1; n <= 4; n++)
      for (int sel = 0; sel < 4; sel++) begin
        int d;
        d = 1 << n;
        setup(1'b1, sel, 1'b0, n);
        sig_in = !exp_lvl;
        for (int i = 1; i <= d; i++) begin
          noise(sel);
          check(level_o, exp_lvl, "R1", "level on foreign strobe");
          pulse(sel);
          if (i == d) exp_lvl = !exp_lvl;
          check(level_o, exp_lvl, "R4", "filtered level");
          check(tick_o, 1'b0, "R7", "tick in pulse mode");
        end
        sig_in = !exp_lvl;
        for (int i = 1; i < d; i++) pulse(sel);
        sig_in = exp_lvl;
        @(negedge clk);
        sig_in = !exp_lvl;
        for (int i = 1; i < d; i++) begin
          pulse(sel);
          check(level_o, exp_lvl, "R5", "level after return");
        end
        pulse(sel);
        exp_lvl = !exp_lvl;
        check(level_o, exp_lvl, "R5", "level after restarted count");
      end

    // R6: N=0 and bypass follow the input
    for (int k = 0; k < 2; k++) begin
      setup(1'b1, 1, k[0], k ? 3 : 0);
      for (int i = 0; i < 6; i++) begin
        sig_in = !sig_in;
        @(negedge clk);
        exp_lvl = sig_in;
        check(level_o, exp_lvl, "R6", "pass-through level");
      end
    end

    // R8: disable holds level
    tmr_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      sig_in = !sig_in;
      @(negedge clk);
      check(level_o, exp_lvl, "R8", "level held when disabled");
    end

    // R8: disable clears the divider
    setup(1'b0, 2, 1'b0, 1);
    for (int i = 0; i < 3; i++) begin
      pulse(2);
      check(tick_o, 1'b0, "R8", "tick before disable");
    end
    tmr_en = 1'b0;
    pulse(2);
    check(tick_o, 1'b0, "R8", "tick while disabled");
    tmr_en = 1'b1;
    @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      pulse(2);
      check(tick_o, i == 4, "R8", "tick after re-enable");
    end

    // R9: source change clears
    setup(1'b0, 0, 1'b0, 1);
    for (int i = 0; i < 3; i++) pulse(0);
    src_sel = 2'd1;
    @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      pulse(1);
      check(tick_o, i == 4, "R9", "tick after source change");
    end

    // R9: shift change clears
    for (int i = 0; i < 3; i++) pulse(1);
    shift_n = 4'd2;
    @(negedge clk);
    for (int i = 1; i <= 8; i++) begin
      pulse(1);
      check(tick_o, i == 8, "R9", "tick after shift change");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule